// File: doc/BRIEF.md
# DMA Source Cell Address Generator

This block produces the read address sequence for the source side of one DMA channel that moves data in cells. A cell is a run of bytes whose length comes from the cell-size input. Inside a cell the address steps forward by the access width on every accepted beat. When the final beat of a cell is accepted, the address jumps to the start of the next cell. That start is the previous cell start, plus the cell length, plus a programmable 16-bit stride.

Software programs the stride through a small write port, and can read it back at any time. While the channel is enabled the stride is locked, and writes to it are dropped. A programmed stride of zero stands for a stride equal to the cell length. At every cell boundary the stride is checked against the alignment that the read-access-size code demands. A misaligned stride stops the walk at that boundary and raises a sticky error flag.

Top module: `dsca_src_cell_addr`

## Requirements
- R1: After synchronous reset, the stride readback is 0, `busy` is 0, `align_err` is 0 and `rd_addr` is 0.
- R2: With `chan_en` low, a `cfg_wr_en` pulse stores `cfg_wr_data` as the stride, and `cfg_rd_data` shows it from the next cycle onward.
- R3: With `chan_en` high, a `cfg_wr_en` pulse is ignored, and `cfg_rd_data` keeps its old value.
- R4: A `start` pulse with `chan_en` high loads `start_addr` into `rd_addr` and into the cell start, reloads the byte count from `cell_size`, sets `busy` and clears `align_err`, all on the next cycle.
- R5: The access width is 2 bytes for `ras_code` 3'b001 or 3'b100, and 4 bytes for 3'b101. For 3'b010 it is 4 bytes when `word_only` is 1 and 1 byte when `word_only` is 0. Every other code gives 1 byte. Each accepted beat that is not the last of its cell adds the access width to `rd_addr`.
- R6: `cell_last` is 1 while busy, when the bytes left in the cell are no more than the access width. An accepted beat with `cell_last` high and an aligned stride sets `rd_addr` to the cell start plus `cell_size` plus the stride.
- R7: A stride of 0 acts as a stride equal to `cell_size`, so the next cell starts at the cell start plus twice `cell_size`.
- R8: For a 2-byte access width, stride bit 0 must be 0. For a 4-byte width, stride bits 1:0 must be 0. An accepted last beat with a misaligned stride sets `align_err` and leaves `rd_addr` unchanged. While `align_err` is set, beats are ignored.
- R9: `err_clr` clears `align_err` unless a new error is raised in the same cycle. A `start` also clears it.
- R10: While `chan_en` is low, `busy` drops on the next cycle, and `start` and `beat` have no effect on `rd_addr`.
- R11: Address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Stride write strobe |
| cfg_wr_data | input | 16 | Stride write value |
| cfg_rd_data | output | 16 | Stride readback |
| chan_en | input | 1 | Channel enable; also locks the stride |
| start | input | 1 | Begin a transfer at `start_addr` |
| start_addr | input | 32 | First source byte address |
| cell_size | input | 16 | Cell length in bytes |
| ras_code | input | 3 | Read-access-size code |
| word_only | input | 1 | Selects 4-byte accesses for code 3'b010 |
| beat | input | 1 | One access at `rd_addr` has been accepted |
| err_clr | input | 1 | Clears the alignment error flag |
| rd_addr | output | 32 | Current source byte address |
| cell_last | output | 1 | Current beat is the final one of its cell |
| busy | output | 1 | Channel is walking cells |
| align_err | output | 1 | Sticky stride misalignment flag |

## Verification
The bound checker watches, on every cycle, that the stride is locked while enabled and that it is loaded while disabled. It also checks that a start loads the address, that an in-cell beat adds exactly the access width, and that the address freezes while an error is pending. Further checks cover the error clear, the drop of `busy` when the channel is disabled, and the reset values. The cell-boundary jump depends on the hidden cell start, so only the bench can show it, by comparing against its own model. The same holds for zero-stride substitution, wrap at 2^32, and which codes count as misaligned. The bench reaches these cases through directed scenarios and a long pseudo-random run.

// File: rtl/dsca_pkg.sv
`timescale 1ns/1ps
package dsca_pkg;

    localparam int unsigned ADDR_W_DEF   = 32;
    localparam int unsigned STRIDE_W_DEF = 16;
    localparam int unsigned CSIZE_W_DEF  = 16;
    localparam int unsigned RAS_W        = 3;

    // Access width in bytes, encoded as its own value
    typedef enum logic [2:0] {
        ACC_BYTE = 3'd1,
        ACC_HALF = 3'd2,
        ACC_WORD = 3'd4
    } acc_e;

    localparam logic [RAS_W-1:0] RAS_HALF_A = 3'b001;
    localparam logic [RAS_W-1:0] RAS_HALF_B = 3'b100;
    localparam logic [RAS_W-1:0] RAS_WORD   = 3'b101;
    localparam logic [RAS_W-1:0] RAS_MIXED  = 3'b010;

    // Decision taken by the walker for one accepted beat
    typedef struct packed {
        logic step;   // advance inside the cell
        logic roll;   // move to next cell start
        logic fault;  // misaligned stride at boundary
    } beat_act_t;

    function automatic acc_e acc_of(input logic [RAS_W-1:0] ras, input logic word_only);
        acc_e a;
        case (ras)
            RAS_HALF_A, RAS_HALF_B: a = ACC_HALF;
            RAS_WORD:               a = ACC_WORD;
            RAS_MIXED:              a = word_only ? ACC_WORD : ACC_BYTE;
            default:                a = ACC_BYTE;
        endcase
        return a;
    endfunction

    function automatic logic stride_bad(input logic [1:0] low, input acc_e a);
        logic bad;
        case (a)
            ACC_HALF: bad = low[0];
            ACC_WORD: bad = (low != 2'b00);
            default:  bad = 1'b0;
        endcase
        return bad;
    endfunction

endpackage

// File: rtl/dsca_stride_reg.sv
`timescale 1ns/1ps
module dsca_stride_reg #(
    parameter int unsigned SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_data,
    input  logic          lock,
    output logic [SW-1:0] stride_q
);
    logic accept;

    assign accept = wr_en && !lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            stride_q <= '0;
        end else if (accept) begin
            stride_q <= wr_data;
        end
    end
endmodule

// File: rtl/dsca_step_calc.sv
`timescale 1ns/1ps
module dsca_step_calc
    import dsca_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned SW = 16,
    parameter int unsigned CW = 16
) (
    input  logic [SW-1:0]    stride,
    input  logic [CW-1:0]    cell_size,
    input  logic [RAS_W-1:0] ras_code,
    input  logic             word_only,
    output acc_e             acc,
    output logic             misaligned,
    output logic [AW-1:0]    cell_step
);
    localparam int unsigned WIDEST = (CW > SW) ? CW : SW;
    localparam int unsigned STEP_W = WIDEST + 1;

    logic [STEP_W-1:0] eff_stride;
    logic [STEP_W-1:0] size_ext;
    logic [STEP_W-1:0] stride_ext;
    logic              stride_zero;

    assign stride_zero = (stride == '0);
    assign size_ext    = STEP_W'(cell_size);
    assign stride_ext  = STEP_W'(stride);

    generate
        if (SW >= 2) begin : g_low_bits
            assign misaligned = stride_bad(stride[1:0], acc);
        end else begin : g_one_bit
            assign misaligned = stride_bad({1'b0, stride[0]}, acc);
        end
    endgenerate

    always_comb begin
        acc        = acc_of(ras_code, word_only);
        eff_stride = stride_zero ? size_ext : stride_ext;
        cell_step  = AW'(size_ext) + AW'(eff_stride);
    end
endmodule

// File: rtl/dsca_walker.sv
`timescale 1ns/1ps
module dsca_walker
    import dsca_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chan_en,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] cell_size,
    input  logic          beat,
    input  logic          err_clr,
    input  acc_e          acc,
    input  logic          misaligned,
    input  logic [AW-1:0] cell_step,
    output logic [AW-1:0] rd_addr,
    output logic          cell_last,
    output logic          busy,
    output logic          align_err
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] cstart_q;
    logic [CW-1:0] left_q;
    logic          busy_q;
    logic          err_q;
    logic          launch;
    logic          take;
    logic [CW-1:0] acc_cw;
    logic [AW-1:0] next_cell;
    beat_act_t     act;

    assign acc_cw    = CW'(acc);
    assign launch    = chan_en && start;
    assign take      = chan_en && !start && busy_q && beat && !err_q;
    assign cell_last = busy_q && (left_q <= acc_cw);
    assign next_cell = cstart_q + cell_step;

    always_comb begin
        act       = '0;
        act.step  = take && !cell_last;
        act.roll  = take && cell_last && !misaligned;
        act.fault = take && cell_last && misaligned;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            cstart_q <= '0;
            left_q   <= '0;
            busy_q   <= 1'b0;
        end else if (!chan_en) begin
            busy_q <= 1'b0;
        end else if (launch) begin
            addr_q   <= start_addr;
            cstart_q <= start_addr;
            left_q   <= cell_size;
            busy_q   <= 1'b1;
        end else if (act.step) begin
            addr_q <= addr_q + AW'(acc);
            left_q <= left_q - acc_cw;
        end else if (act.roll) begin
            addr_q   <= next_cell;
            cstart_q <= next_cell;
            left_q   <= cell_size;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (launch) begin
            err_q <= 1'b0;
        end else if (act.fault) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

    assign rd_addr   = addr_q;
    assign busy      = busy_q;
    assign align_err = err_q;
endmodule

// File: rtl/dsca_src_cell_addr.sv
`timescale 1ns/1ps
module dsca_src_cell_addr
    import dsca_pkg::*;
#(
    parameter int unsigned AW = ADDR_W_DEF,
    parameter int unsigned SW = STRIDE_W_DEF,
    parameter int unsigned CW = CSIZE_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic [SW-1:0]    cfg_wr_data,
    output logic [SW-1:0]    cfg_rd_data,
    input  logic             chan_en,
    input  logic             start,
    input  logic [AW-1:0]    start_addr,
    input  logic [CW-1:0]    cell_size,
    input  logic [RAS_W-1:0] ras_code,
    input  logic             word_only,
    input  logic             beat,
    input  logic             err_clr,
    output logic [AW-1:0]    rd_addr,
    output logic             cell_last,
    output logic             busy,
    output logic             align_err
);
    logic [SW-1:0] stride_q;
    acc_e          acc;
    logic          misaligned;
    logic [AW-1:0] cell_step;

    dsca_stride_reg #(.SW(SW)) u_stride (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .lock     (chan_en),
        .stride_q (stride_q)
    );

    dsca_step_calc #(.AW(AW), .SW(SW), .CW(CW)) u_step (
        .stride     (stride_q),
        .cell_size  (cell_size),
        .ras_code   (ras_code),
        .word_only  (word_only),
        .acc        (acc),
        .misaligned (misaligned),
        .cell_step  (cell_step)
    );

    dsca_walker #(.AW(AW), .CW(CW)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .chan_en    (chan_en),
        .start      (start),
        .start_addr (start_addr),
        .cell_size  (cell_size),
        .beat       (beat),
        .err_clr    (err_clr),
        .acc        (acc),
        .misaligned (misaligned),
        .cell_step  (cell_step),
        .rd_addr    (rd_addr),
        .cell_last  (cell_last),
        .busy       (busy),
        .align_err  (align_err)
    );

    assign cfg_rd_data = stride_q;
endmodule

// File: rtl/dsca_src_cell_addr_chk.sv
`timescale 1ns/1ps
module dsca_src_cell_addr_chk
    import dsca_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned SW = 16,
    parameter int unsigned CW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr_en,
    input logic [SW-1:0]    cfg_wr_data,
    input logic [SW-1:0]    cfg_rd_data,
    input logic             chan_en,
    input logic             start,
    input logic [AW-1:0]    start_addr,
    input logic [CW-1:0]    cell_size,
    input logic [RAS_W-1:0] ras_code,
    input logic             word_only,
    input logic             beat,
    input logic             err_clr,
    input logic [AW-1:0]    rd_addr,
    input logic             cell_last,
    input logic             busy,
    input logic             align_err
);
    acc_e acc_now;
    logic rst_q;

    always_comb acc_now = acc_of(ras_code, word_only);

    always_ff @(posedge clk) rst_q <= rst;

    // R1: values seen right after a reset cycle
    always @(negedge clk) begin
        if (rst_q === 1'b1) begin
            assert_reset_vals_R1: assert (cfg_rd_data == '0 && !busy && !align_err && rd_addr == '0)
                else $error("reset values wrong");
        end
    end

    assert_wr_open_R2: assert property (@(posedge clk) disable iff (rst)
        (!chan_en && cfg_wr_en) |=> (cfg_rd_data == $past(cfg_wr_data)));

    assert_wr_locked_R3: assert property (@(posedge clk) disable iff (rst)
        (chan_en && cfg_wr_en) |=> $stable(cfg_rd_data));

    assert_start_load_R4: assert property (@(posedge clk) disable iff (rst)
        (chan_en && start) |=> (busy && !align_err && rd_addr == $past(start_addr)));

    assert_beat_step_R5: assert property (@(posedge clk) disable iff (rst)
        (chan_en && busy && beat && !start && !align_err && !cell_last)
        |=> (rd_addr == $past(rd_addr) + AW'($past(acc_now))));

    assert_err_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        (align_err && !(chan_en && start)) |=> $stable(rd_addr));

    assert_err_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !beat) |=> !align_err);

    assert_disable_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> (!busy && $stable(rd_addr)));
endmodule

bind dsca_src_cell_addr dsca_src_cell_addr_chk #(.AW(AW), .SW(SW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .chan_en     (chan_en),
    .start       (start),
    .start_addr  (start_addr),
    .cell_size   (cell_size),
    .ras_code    (ras_code),
    .word_only   (word_only),
    .beat        (beat),
    .err_clr     (err_clr),
    .rd_addr     (rd_addr),
    .cell_last   (cell_last),
    .busy        (busy),
    .align_err   (align_err)
);

// File: tb/dsca_src_cell_addr_test.sv
`timescale 1ns/1ps
module dsca_src_cell_addr_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wr_data = '0;
    logic [15:0] cfg_rd_data;
    logic        chan_en = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [15:0] cell_size = 16'd1;
    logic [2:0]  ras_code = '0;
    logic        word_only = 1'b0;
    logic        beat = 1'b0;
    logic        err_clr = 1'b0;
    logic [31:0] rd_addr;
    logic        cell_last;
    logic        busy;
    logic        align_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [15:0] m_stride;
    logic        m_busy, m_err;
    logic [31:0] m_addr, m_cs;
    int          m_left;

    always #2 clk = ~clk;

    dsca_src_cell_addr uut (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .chan_en(chan_en), .start(start),
        .start_addr(start_addr), .cell_size(cell_size), .ras_code(ras_code),
        .word_only(word_only), .beat(beat), .err_clr(err_clr), .rd_addr(rd_addr),
        .cell_last(cell_last), .busy(busy), .align_err(align_err)
    );

    function automatic int width_of(input logic [2:0] c, input logic w);
        if (c == 3'b001 || c == 3'b100) return 2;
        if (c == 3'b101) return 4;
        if (c == 3'b010) return w ? 4 : 1;
        return 1;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle model
    always @(posedge clk) begin
        int a;
        bit last, bad, old_err;
        longint sum;
        if (rst) begin
            m_stride = 0; m_busy = 0; m_err = 0; m_addr = 0; m_cs = 0; m_left = 0;
        end else begin
            a       = width_of(ras_code, word_only);
            last    = m_busy && (m_left <= a);
            bad     = (m_stride % a) != 0;
            old_err = m_err;
            if (chan_en && start) m_err = 0;
            else if (chan_en && m_busy && beat && !old_err && last && bad) m_err = 1;
            else if (err_clr) m_err = 0;
            if (!chan_en) begin
                m_busy = 0;
            end else if (start) begin
                m_busy = 1; m_addr = start_addr; m_cs = start_addr; m_left = cell_size;
            end else if (m_busy && beat && !old_err) begin
                if (!last) begin
                    m_addr = m_addr + 32'(a); m_left = m_left - a;
                end else if (!bad) begin
                    sum = longint'(m_cs) + longint'(cell_size) +
                          ((m_stride == 0) ? longint'(cell_size) : longint'(m_stride));
                    m_cs = 32'(sum); m_addr = 32'(sum); m_left = cell_size;
                end
            end
            if (!chan_en && cfg_wr_en) m_stride = cfg_wr_data;
        end
    end

    always @(posedge clk) begin
        #1;
        if (!rst) begin
            check("R2 cfg_rd_data", cfg_rd_data, m_stride);
            check("R5 rd_addr", rd_addr, m_addr);
            check("R4 busy", busy, m_busy);
            check("R8 align_err", align_err, m_err);
            check("R6 cell_last", cell_last,
                  m_busy && (m_left <= width_of(ras_code, word_only)));
        end
    end

    task automatic tick;
        @(negedge clk);
        start = 0; cfg_wr_en = 0; err_clr = 0; beat = 0;
    endtask

    task automatic wr_stride(input logic [15:0] v);
        chan_en = 0; tick();
        cfg_wr_en = 1; cfg_wr_data = v; tick();
    endtask

    task automatic launch(input logic [31:0] a, input logic [15:0] sz,
                          input logic [2:0] c, input logic w);
        chan_en = 1; cell_size = sz; ras_code = c; word_only = w;
        start = 1; start_addr = a; tick();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 stride", cfg_rd_data, 0);
        check("R1 busy", busy, 0);
        check("R1 err", align_err, 0);
        check("R1 addr", rd_addr, 0);

        wr_stride(16'd8);
        check("R2 write open", cfg_rd_data, 8);
        chan_en = 1; cfg_wr_en = 1; cfg_wr_data = 16'h1234; tick();
        check("R3 write locked", cfg_rd_data, 8);

        launch(32'h1000, 16'd6, 3'b001, 0);
        check("R4 load addr", rd_addr, 32'h1000);
        check("R4 busy", busy, 1);
        beat = 1; tick();
        check("R5 half step", rd_addr, 32'h1002);
        beat = 1; tick();
        check("R6 last flag", cell_last, 1);
        beat = 1; tick();
        check("R6 next cell", rd_addr, 32'h100E);

        wr_stride(16'd0);
        launch(32'h2000, 16'd6, 3'b000, 0);
        repeat (6) begin beat = 1; tick(); end
        check("R7 zero stride", rd_addr, 32'h200C);

        launch(32'h3000, 16'd8, 3'b010, 1);
        beat = 1; tick();
        check("R5 word step", rd_addr, 32'h3004);
        beat = 1; tick();
        check("R7 word cell", rd_addr, 32'h3010);

        wr_stride(16'd6);
        launch(32'h4000, 16'd4, 3'b101, 0);
        beat = 1; tick();
        check("R8 err set", align_err, 1);
        check("R8 addr held", rd_addr, 32'h4000);
        beat = 1; tick();
        check("R8 beat ignored", rd_addr, 32'h4000);
        err_clr = 1; tick();
        check("R9 clear", align_err, 0);
        beat = 1; tick();
        check("R8 err again", align_err, 1);
        launch(32'h4100, 16'd4, 3'b101, 0);
        check("R9 start clears", align_err, 0);

        launch(32'h5000, 16'd4, 3'b100, 0);
        beat = 1; tick();
        beat = 1; tick();
        check("R6 half aligned", rd_addr, 32'h500A);
        check("R8 no err", align_err, 0);

        wr_stride(16'h0010);
        launch(32'hFFFF_FFF8, 16'd1, 3'b000, 0);
        beat = 1; tick();
        check("R11 wrap", rd_addr, 32'h0000_0009);

        chan_en = 0; tick();
        check("R10 busy drop", busy, 0);
        beat = 1; start = 1; start_addr = 32'hABCD; tick();
        check("R10 ignored", rd_addr, 32'h0000_0009);

        r = 32'h1357_9BDF;
        for (int i = 0; i < 4000; i++) begin
            r = r * 32'd1664525 + 32'd1013904223;
            chan_en     = (r[27:24] != 4'd0);
            start       = (r[31:27] == 5'd3);
            beat        = r[20];
            err_clr     = (r[17:13] == 5'd9);
            cfg_wr_en   = (r[10:8] == 3'd2);
            cfg_wr_data = 16'(r[6:3]);
            cell_size   = 16'(r[22:21]) * 16'd2 + 16'(r[12]) + 16'd1;
            ras_code    = r[2:0];
            word_only   = r[23];
            start_addr  = {r[15:0], r[31:16]};
            @(negedge clk);
        end
        tick();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule